// File: doc/BRIEF.md
# Data Bus Byte-Lane Parity Unit

This unit guards a 64-bit processor data bus with one even-parity bit per byte lane. During a write it computes the eight lane parity bits from the outgoing data and drives them. Driving begins one clock after the address strobe. For a single transfer the bits stay fixed until the ready edge. For a four-beat burst writeback they are refreshed on every ready edge, using the beat data that the system presents with that ready.

During a read the unit captures the incoming data, byte enables and parity bits on each ready edge. It checks only the enabled lanes. If any enabled lane is wrong, it pulls an active-low check output low for one clock, starting on the following edge.

The pad tristate is modelled as a parity value plus an output-enable. Backoff and hold-acknowledge abandon the current cycle and float the bits. A parity error never changes the flow of the bus cycle.

Top module: `bus_par_unit`

## Requirements
- R1: Driven parity bit n equals the XOR of data bits [8n+7:8n], so each lane plus its parity bit holds an even count of ones. Bit 0 covers the lowest byte and bit 7 the highest.
- R2: After an address strobe (ads_n low) with wr high is sampled at an edge, par_oe stays low after that edge. It goes high on the next edge, with parity taken from the write data present at that edge.
- R3: In a single-transfer write (burst low at the strobe), par_out holds its value while rdy_n stays high, even if the write data changes. par_oe drops on the edge where rdy_n is sampled low.
- R4: In a burst write (burst high at the strobe), each of the first three ready edges loads the parity of the write data present at that edge. par_oe drops on the fourth ready edge.
- R5: On a read, when rdy_n is sampled low and any enabled lane's sampled parity bit differs from the even parity of its data byte, pchk_n is low for exactly the one clock after that edge. Otherwise pchk_n stays high.
- R6: A lane whose be_n bit is high never causes pchk_n to go low, whatever its data and parity.
- R7: par_oe is low whenever no write is being driven, including idle time and the whole of a read cycle.
- R8: On an edge where boff_n is sampled low, par_oe goes low and the cycle is abandoned. It does not resume when boff_n returns high.
- R9: On an edge where hlda is sampled high, par_oe goes low and the cycle is abandoned.
- R10: Synchronous active-high rst sets par_oe low and pchk_n high, and returns the unit to idle.
- R11: A parity error does not shorten or stop a cycle. A read burst with errors still completes all four ready beats, each one checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ads_n | input | 1 | Address strobe, active low |
| wr | input | 1 | Cycle is a write when high, sampled with the strobe |
| burst | input | 1 | Cycle is a four-beat burst, sampled with the strobe |
| rdy_n | input | 1 | Transfer ready, active low |
| be_n | input | 8 | Byte enables, active low, bit n for lane n |
| boff_n | input | 1 | Backoff, active low |
| hlda | input | 1 | Hold acknowledge, active high |
| wdata | input | 64 | Outgoing data for the current write beat |
| rdata | input | 64 | Incoming data bus during reads |
| par_in | input | 8 | Parity bits sampled from the bus |
| par_out | output | 8 | Parity bits to drive onto the bus |
| par_oe | output | 1 | Drive enable for par_out; low means floated |
| pchk_n | output | 1 | Parity check pulse, active low |

## Verification
The assertions assume that ready is never asserted in the clock between the strobe and the start of parity driving. They also assume that a new strobe is not presented while a cycle is still open. The stimulus keeps to both rules. It raises the strobe after one clock, raises ready only while a cycle is open, and counts ready beats exactly. Backoff and hold-acknowledge are applied only while a write is being driven, then released before the next cycle starts. This keeps every rise of the drive enable traceable to a strobe two edges earlier.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WPREP = 2'd1,
        ST_WDRV  = 2'd2,
        ST_READ  = 2'd3
    } bus_st_e;
endpackage

// File: rtl/bpar_lane_gen.sv
module bpar_lane_gen #(
    parameter int BYTES = 8
) (
    input  logic [BYTES*8-1:0] data,
    output logic [BYTES-1:0]   par
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign par[g] = ^data[g*8 +: 8];
    end
endmodule

// File: rtl/bpar_mismatch.sv
module bpar_mismatch #(
    parameter int BYTES = 8
) (
    input  logic [BYTES-1:0] calc_par,
    input  logic [BYTES-1:0] bus_par,
    input  logic [BYTES-1:0] be_n,
    output logic             err
);
    logic [BYTES-1:0] bad;
    for (genvar g = 0; g < BYTES; g++) begin : g_cmp
        assign bad[g] = !be_n[g] && (calc_par[g] != bus_par[g]);
    end
    assign err = |bad;
endmodule

// File: rtl/bpar_ctrl.sv
module bpar_ctrl
    import bpar_pkg::*;
#(
    parameter int BYTES = 8,
    parameter int BEATS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ads_n,
    input  logic             wr,
    input  logic             burst,
    input  logic             rdy_n,
    input  logic             boff_n,
    input  logic             hlda,
    input  logic [BYTES-1:0] wr_par,
    input  logic             rd_err,
    output logic [BYTES-1:0] par_out,
    output logic             par_oe,
    output logic             pchk_n
);
    localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

    typedef struct packed {
        bus_st_e          st;
        logic [CW-1:0]    beat;
        logic             bst;
        logic             oe;
        logic [BYTES-1:0] par;
        logic             pchk_n;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic last_beat;

    always_comb begin
        last_beat = !ctl_q.bst || (ctl_q.beat == LAST);
        ctl_d = ctl_q;
        ctl_d.pchk_n = 1'b1;
        if (!boff_n || hlda) begin
            ctl_d.st   = ST_IDLE;
            ctl_d.oe   = 1'b0;
            ctl_d.beat = '0;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (!ads_n) begin
                        ctl_d.bst  = burst;
                        ctl_d.beat = '0;
                        ctl_d.st   = wr ? ST_WPREP : ST_READ;
                    end
                end
                ST_WPREP: begin
                    ctl_d.st  = ST_WDRV;
                    ctl_d.oe  = 1'b1;
                    ctl_d.par = wr_par;
                end
                ST_WDRV: begin
                    if (!rdy_n) begin
                        if (last_beat) begin
                            ctl_d.st = ST_IDLE;
                            ctl_d.oe = 1'b0;
                        end else begin
                            ctl_d.beat = ctl_q.beat + 1'b1;
                            ctl_d.par  = wr_par;
                        end
                    end
                end
                ST_READ: begin
                    if (!rdy_n) begin
                        ctl_d.pchk_n = !rd_err;
                        if (last_beat) ctl_d.st = ST_IDLE;
                        else           ctl_d.beat = ctl_q.beat + 1'b1;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st     <= ST_IDLE;
            ctl_q.beat   <= '0;
            ctl_q.bst    <= 1'b0;
            ctl_q.oe     <= 1'b0;
            ctl_q.par    <= '0;
            ctl_q.pchk_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign par_out = ctl_q.par;
    assign par_oe  = ctl_q.oe;
    assign pchk_n  = ctl_q.pchk_n;
endmodule

// File: rtl/bus_par_unit.sv
module bus_par_unit #(
    parameter int BYTES = 8,
    parameter int BEATS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ads_n,
    input  logic               wr,
    input  logic               burst,
    input  logic               rdy_n,
    input  logic [BYTES-1:0]   be_n,
    input  logic               boff_n,
    input  logic               hlda,
    input  logic [BYTES*8-1:0] wdata,
    input  logic [BYTES*8-1:0] rdata,
    input  logic [BYTES-1:0]   par_in,
    output logic [BYTES-1:0]   par_out,
    output logic               par_oe,
    output logic               pchk_n
);
    logic [BYTES-1:0] wr_par;
    logic [BYTES-1:0] rd_calc;
    logic             rd_err;

    bpar_lane_gen #(.BYTES(BYTES)) i_gen_wr (
        .data (wdata),
        .par  (wr_par)
    );

    bpar_lane_gen #(.BYTES(BYTES)) i_gen_rd (
        .data (rdata),
        .par  (rd_calc)
    );

    bpar_mismatch #(.BYTES(BYTES)) i_cmp (
        .calc_par (rd_calc),
        .bus_par  (par_in),
        .be_n     (be_n),
        .err      (rd_err)
    );

    bpar_ctrl #(.BYTES(BYTES), .BEATS(BEATS)) i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ads_n  (ads_n),
        .wr     (wr),
        .burst  (burst),
        .rdy_n  (rdy_n),
        .boff_n (boff_n),
        .hlda   (hlda),
        .wr_par (wr_par),
        .rd_err (rd_err),
        .par_out(par_out),
        .par_oe (par_oe),
        .pchk_n (pchk_n)
    );
endmodule

// File: rtl/bpar_sva.sv
module bpar_sva #(
    parameter int BYTES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ads_n,
    input logic             rdy_n,
    input logic             boff_n,
    input logic             hlda,
    input logic [BYTES-1:0] par_out,
    input logic             par_oe,
    input logic             pchk_n
);
    AST_OE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(par_oe) |-> $past(!ads_n, 2)); // R2

    AST_PAR_HELD: assert property (@(posedge clk) disable iff (rst)
        (par_oe && $past(par_oe) && $past(rdy_n)) |-> $stable(par_out)); // R3

    AST_PCHK_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        !pchk_n |-> $past(!rdy_n)); // R5

    AST_PCHK_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !pchk_n |-> !par_oe); // R7

    AST_BOFF_FLOAT: assert property (@(posedge clk) disable iff (rst)
        !boff_n |=> !par_oe); // R8

    AST_HLDA_FLOAT: assert property (@(posedge clk) disable iff (rst)
        hlda |=> !par_oe); // R9
endmodule

bind bus_par_unit bpar_sva #(.BYTES(BYTES)) i_bpar_sva (
    .clk    (clk),
    .rst    (rst),
    .ads_n  (ads_n),
    .rdy_n  (rdy_n),
    .boff_n (boff_n),
    .hlda   (hlda),
    .par_out(par_out),
    .par_oe (par_oe),
    .pchk_n (pchk_n)
);

// File: tb/test_bus_par_unit.sv
module test_bus_par_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ads_n = 1'b1, wr = 1'b0, burst = 1'b0, rdy_n = 1'b1;
    logic [7:0]  be_n = 8'h00;
    logic        boff_n = 1'b1, hlda = 1'b0;
    logic [63:0] wdata = '0, rdata = '0;
    logic [7:0]  par_in = '0;
    logic [7:0]  par_out;
    logic        par_oe, pchk_n;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    bus_par_unit i_bus_par_unit (
        .clk(clk), .rst(rst), .ads_n(ads_n), .wr(wr), .burst(burst),
        .rdy_n(rdy_n), .be_n(be_n), .boff_n(boff_n), .hlda(hlda),
        .wdata(wdata), .rdata(rdata), .par_in(par_in),
        .par_out(par_out), .par_oe(par_oe), .pchk_n(pchk_n)
    );

    // data, be_n, parity flip mask
    localparam logic [79:0] VECS [8] = '{
        {64'h0123456789ABCDEF, 8'h00, 8'h00},
        {64'h0123456789ABCDEF, 8'h00, 8'h01},
        {64'hFFFFFFFFFFFFFFFF, 8'h00, 8'h80},
        {64'h0000000000000000, 8'h80, 8'h80},
        {64'hA5A5A5A5A5A5A5A5, 8'hFE, 8'h01},
        {64'hA5A5A5A5A5A5A5A5, 8'hFE, 8'h02},
        {64'h8000000000000001, 8'hFF, 8'hFF},
        {64'h1122334455667788, 8'h0F, 8'h10}
    };

    function automatic logic [7:0] even_par(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ^d[i*8 +: 8];
        return p;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_write(input logic bst, input logic [63:0] d);
        ads_n = 1'b0; wr = 1'b1; burst = bst;
        step();
        check("R2 no drive at strobe edge", {63'd0, par_oe}, 64'd0);
        ads_n = 1'b1; wdata = d;
        step();
        check("R2 drive enable", {63'd0, par_oe}, 64'd1);
        check("R1 lane parity", {56'd0, par_out}, {56'd0, even_par(d)});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        check("R10 reset oe", {63'd0, par_oe}, 64'd0);
        check("R10 reset pchk", {63'd0, pchk_n}, 64'd1);
        rst = 1'b0;
        step();

        // Table-driven single reads: R5, R6, R7
        for (int v = 0; v < 8; v++) begin
            logic [63:0] d;
            logic [7:0]  be, fl;
            logic        exp_err;
            {d, be, fl} = VECS[v];
            exp_err = |(fl & ~be);
            ads_n = 1'b0; wr = 1'b0; burst = 1'b0;
            step();
            check("R7 no drive on read", {63'd0, par_oe}, 64'd0);
            ads_n = 1'b1; rdata = d; be_n = be; par_in = even_par(d) ^ fl; rdy_n = 1'b0;
            step();
            check(exp_err ? "R5 error pulse" : "R6 enabled lanes only",
                  {63'd0, pchk_n}, {63'd0, !exp_err});
            check("R7 no drive after read ready", {63'd0, par_oe}, 64'd0);
            rdy_n = 1'b1; be_n = 8'h00;
            step();
            check("R5 one clock pulse", {63'd0, pchk_n}, 64'd1);
        end

        // Single write: R1, R2, R3
        start_write(1'b0, 64'h00FF_0180_7F01_0203);
        wdata = 64'h1111_2222_3333_4444;
        step();
        check("R3 hold without ready", {56'd0, par_out}, {56'd0, even_par(64'h00FF_0180_7F01_0203)});
        check("R3 still driving", {63'd0, par_oe}, 64'd1);
        rdy_n = 1'b0;
        step();
        check("R3 float at ready", {63'd0, par_oe}, 64'd0);
        rdy_n = 1'b1;
        step();

        // Burst writeback: R4
        start_write(1'b1, 64'hDEAD_BEEF_0000_0001);
        for (int k = 1; k < 4; k++) begin
            logic [63:0] bd;
            bd = 64'h0102_0408_1020_4080 * (k + 3);
            wdata = bd; rdy_n = 1'b0;
            step();
            check("R4 beat parity", {56'd0, par_out}, {56'd0, even_par(bd)});
            check("R4 still driving", {63'd0, par_oe}, 64'd1);
        end
        step();
        check("R4 float after fourth ready", {63'd0, par_oe}, 64'd0);
        rdy_n = 1'b1;
        step();

        // Backoff: R8
        start_write(1'b1, 64'h5555_0000_AAAA_1234);
        boff_n = 1'b0;
        step();
        check("R8 float on backoff", {63'd0, par_oe}, 64'd0);
        boff_n = 1'b1;
        step(); step();
        check("R8 cycle abandoned", {63'd0, par_oe}, 64'd0);

        // Hold acknowledge: R9
        start_write(1'b0, 64'h7777_8888_9999_AAAA);
        hlda = 1'b1;
        step();
        check("R9 float on hlda", {63'd0, par_oe}, 64'd0);
        hlda = 1'b0;
        step();
        check("R9 cycle abandoned", {63'd0, par_oe}, 64'd0);

        // Read burst with errors keeps running: R11
        ads_n = 1'b0; wr = 1'b0; burst = 1'b1;
        step();
        ads_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic [63:0] rd;
            logic        er;
            rd = 64'h0F0E_0D0C_0B0A_0908 + 64'(k);
            er = (k == 0) || (k == 3);
            rdata = rd; par_in = even_par(rd) ^ (er ? 8'h04 : 8'h00); rdy_n = 1'b0;
            step();
            check("R11 each burst beat checked", {63'd0, pchk_n}, {63'd0, !er});
        end
        rdy_n = 1'b1;
        step();
        check("R11 pulse ends", {63'd0, pchk_n}, 64'd1);

        // Reset during a driven write: R10
        start_write(1'b0, 64'h0000_0000_0000_00FF);
        rst = 1'b1;
        step();
        check("R10 reset floats", {63'd0, par_oe}, 64'd0);
        rst = 1'b0;
        step(); step();
        check("R10 idle after reset", {63'd0, par_oe}, 64'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule